// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This execution-stage unit takes two 32-bit operand words, forms their product, and adds that product to a 64-bit accumulator held in a LO register. A companion HI register always holds the extension of LO, so the two registers together read as one 128-bit quantity. Each request selects how the operands are read, signed or unsigned. It also selects whether the sum is clamped on overflow, and whether the destination output returns HI or LO.

The clamp limits are asymmetric and depend on the mode. In signed mode a clamped result is confined to the 32-bit signed range, even though the accumulator is 64 bits wide. In unsigned mode only an overflow is clamped, to all ones. Requests are accepted only in the two privileged processor modes. In the other modes the unit flags a reserved-instruction exception and leaves its registers untouched.

Every result is registered on the clock edge that samples the request, so a chain of requests on consecutive cycles accumulates with no gap. Instruction decode, the register file and exception delivery belong to the surrounding pipeline.

Top module: `mac_sat64`

## Requirements
- R1: With `is_unsigned`=1 both operands are read as unsigned 32-bit values. With `is_unsigned`=0 they are read as two's-complement 32-bit values, and the accumulator is then also treated as signed.
- R2: In signed mode with `saturate`=0, LO becomes the low 64 bits of LO + a*b, wrapping without any flag.
- R3: In unsigned mode with `saturate`=0, LO becomes (LO + a*b) mod 2^64.
- R4: In signed mode with `saturate`=1, the full-precision sum is compared against the 32-bit signed range. Above 0x7FFF_FFFF, LO becomes 0x0000_0000_7FFF_FFFF. Below -0x8000_0000, LO becomes 0xFFFF_FFFF_8000_0000. Otherwise the sum is stored as is.
- R5: In unsigned mode with `saturate`=1, a carry out of the 64-bit addition stores 0xFFFF_FFFF_FFFF_FFFF. There is no lower clamp.
- R6: After an accepted request, HI equals 64 copies of LO bit 63 in signed mode, and zero in unsigned mode.
- R7: After an accepted request, `dst_q` equals the new HI when `pick_hi`=1 and the new LO when `pick_hi`=0.
- R8: `cpu_mode` encodes 0 = 32-bit user, 1 = 32-bit supervisor, 2 = 32-bit kernel, 3 = 64-bit. A request in mode 0 or 1 pulses `rsv_exc` one cycle later. It raises no `done`, and it leaves LO, HI and `dst_q` unchanged.
- R9: An accepted request updates LO, HI and `dst_q` and pulses `done` exactly one cycle after `in_valid`. A request in the very next cycle uses the updated LO.
- R10: A synchronous reset clears LO, HI, `dst_q`, `done` and `rsv_exc`.
- R11: In a cycle without `in_valid`, no output changes and neither pulse is raised, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| is_unsigned | input | 1 | 1: unsigned operation, 0: signed |
| saturate | input | 1 | 1: clamp the result on overflow or underflow |
| pick_hi | input | 1 | 1: destination returns HI, 0: returns LO |
| cpu_mode | input | 2 | Processor mode (encoding in R8) |
| lo_q | output | 64 | Accumulator LO register |
| hi_q | output | 64 | Extension HI register |
| dst_q | output | 64 | Destination write value |
| done | output | 1 | One-cycle pulse for an accepted request |
| rsv_exc | output | 1 | One-cycle reserved-instruction exception pulse |

## Verification
The bench builds the unit with its default widths: 32-bit operands and a 64-bit accumulator. At these widths the clamp constants are the exact values the requirements name. An unsigned square of the largest operand lies close enough to 2^64 that two accumulations produce a carry. Products of the most negative operand reach far beyond the 32-bit signed range in both directions. The bench sweeps all eight combinations of the signedness, clamp and destination-select bits across the operand extremes, and its own wide-integer model follows the accumulator as it drifts into wrapped and clamped values.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    MODE_USER32  = 2'd0,
    MODE_SUPV32  = 2'd1,
    MODE_KERN32  = 2'd2,
    MODE_WIDE64  = 2'd3
  } cpu_mode_e;

  // Only the kernel and the 64-bit modes may issue an accumulate.
  function automatic logic mode_permits(cpu_mode_e m);
    return (m == MODE_KERN32) || (m == MODE_WIDE64);
  endfunction

endpackage

// File: rtl/mac_gate.sv
module mac_gate
  import mac_pkg::*;
(
  input  cpu_mode_e mode,
  output logic      permit
);
  assign permit = mode_permits(mode);
endmodule

// File: rtl/mac_mul.sv
module mac_mul #(
  parameter int OPW = 32,
  localparam int PRODW = 2 * OPW
) (
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  input  logic           uns,
  output logic [PRODW:0] prod
);
  // Extend one operand to the product width plus a sign bit.
  function automatic logic signed [PRODW:0] widen(logic [OPW-1:0] v, logic u);
    logic fill;
    fill = u ? 1'b0 : v[OPW-1];
    return {{(OPW+1){fill}}, v};
  endfunction

  logic signed [PRODW:0] ax, bx, full;

  assign ax   = widen(a, uns);
  assign bx   = widen(b, uns);
  // The true product always fits PRODW+1 signed bits.
  assign full = ax * bx;
  assign prod = full;
endmodule

// File: rtl/mac_addsat.sv
module mac_addsat #(
  parameter int OPW  = 32,
  parameter int ACCW = 64,
  localparam int PRODW = 2 * OPW,
  localparam int SUMW  = ACCW + 1
) (
  input  logic [ACCW-1:0] acc,
  input  logic [PRODW:0]  prod,
  input  logic            uns,
  input  logic            sat,
  output logic [ACCW-1:0] res,
  output logic            ovf_ev,
  output logic            unf_ev
);
  localparam logic [SUMW-1:0] SMAX_X = {{(SUMW-OPW+1){1'b0}}, {(OPW-1){1'b1}}};
  localparam logic [SUMW-1:0] SMIN_X = {{(SUMW-OPW+1){1'b1}}, {(OPW-1){1'b0}}};
  localparam logic [ACCW-1:0] SMAX_A = {{(ACCW-OPW+1){1'b0}}, {(OPW-1){1'b1}}};
  localparam logic [ACCW-1:0] SMIN_A = {{(ACCW-OPW+1){1'b1}}, {(OPW-1){1'b0}}};

  logic [SUMW-1:0] prod_x, acc_x, sum;
  logic            gt_max, lt_min;

  generate
    if (SUMW > PRODW + 1) begin : g_prod_ext
      assign prod_x = {{(SUMW-PRODW-1){prod[PRODW]}}, prod};
    end else begin : g_prod_fit
      assign prod_x = prod;
    end
  endgenerate

  function automatic logic [SUMW-1:0] acc_widen(logic [ACCW-1:0] v, logic u);
    return {(u ? 1'b0 : v[ACCW-1]), v};
  endfunction

  function automatic logic [ACCW-1:0] clamp(logic [SUMW-1:0] s, logic u, logic st,
                                            logic ov, logic un);
    if (st && ov)      return u ? {ACCW{1'b1}} : SMAX_A;
    else if (st && un) return SMIN_A;
    else               return s[ACCW-1:0];
  endfunction

  assign acc_x  = acc_widen(acc, uns);
  assign sum    = acc_x + prod_x;
  assign gt_max = $signed(sum) > $signed(SMAX_X);
  assign lt_min = $signed(sum) < $signed(SMIN_X);
  assign ovf_ev = uns ? sum[ACCW] : gt_max;
  assign unf_ev = ~uns & lt_min;
  assign res    = clamp(sum, uns, sat, ovf_ev, unf_ev);
endmodule

// File: rtl/mac_sat64.sv
module mac_sat64
  import mac_pkg::*;
#(
  parameter int OPW  = 32,
  parameter int ACCW = 64,
  localparam int PRODW = 2 * OPW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OPW-1:0]  op_a,
  input  logic [OPW-1:0]  op_b,
  input  logic            is_unsigned,
  input  logic            saturate,
  input  logic            pick_hi,
  input  logic [1:0]      cpu_mode,
  output logic [ACCW-1:0] lo_q,
  output logic [ACCW-1:0] hi_q,
  output logic [ACCW-1:0] dst_q,
  output logic            done,
  output logic            rsv_exc
);
  logic            permit, accept, refuse;
  logic [PRODW:0]  prod;
  logic [ACCW-1:0] acc_next, hi_next, dst_next;
  logic            ovf_ev, unf_ev;

  mac_gate u_gate (
    .mode   (cpu_mode_e'(cpu_mode)),
    .permit (permit)
  );

  mac_mul #(.OPW(OPW)) u_mul (
    .a    (op_a),
    .b    (op_b),
    .uns  (is_unsigned),
    .prod (prod)
  );

  mac_addsat #(.OPW(OPW), .ACCW(ACCW)) u_add (
    .acc    (lo_q),
    .prod   (prod),
    .uns    (is_unsigned),
    .sat    (saturate),
    .res    (acc_next),
    .ovf_ev (ovf_ev),
    .unf_ev (unf_ev)
  );

  assign accept   = in_valid & permit;
  assign refuse   = in_valid & ~permit;
  assign hi_next  = is_unsigned ? '0 : {ACCW{acc_next[ACCW-1]}};
  assign dst_next = pick_hi ? hi_next : acc_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      hi_q    <= '0;
      dst_q   <= '0;
      done    <= 1'b0;
      rsv_exc <= 1'b0;
    end else begin
      done    <= accept;
      rsv_exc <= refuse;
      if (accept) begin
        lo_q  <= acc_next;
        hi_q  <= hi_next;
        dst_q <= dst_next;
      end
    end
  end
endmodule

// File: rtl/mac_sat64_chk.sv
module mac_sat64_chk #(
  parameter int OPW  = 32,
  parameter int ACCW = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            is_unsigned,
  input logic            saturate,
  input logic            pick_hi,
  input logic [1:0]      cpu_mode,
  input logic [ACCW-1:0] lo_q,
  input logic [ACCW-1:0] hi_q,
  input logic [ACCW-1:0] dst_q,
  input logic            done,
  input logic            rsv_exc,
  input logic            ovf_ev,
  input logic            unf_ev
);
  localparam logic [ACCW-1:0] SMIN_A = {{(ACCW-OPW+1){1'b1}}, {(OPW-1){1'b0}}};

  // R8
  refuse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && !cpu_mode[1] |=> rsv_exc && !done && $stable(lo_q) && $stable(hi_q) && $stable(dst_q));

  // R9
  done_next_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && cpu_mode[1] |=> done && !rsv_exc);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !done && !rsv_exc && $stable(lo_q) && $stable(hi_q) && $stable(dst_q));

  // R6
  hi_extend_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> hi_q == ($past(is_unsigned) ? {ACCW{1'b0}} : {ACCW{lo_q[ACCW-1]}}));

  // R7
  dst_select_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> dst_q == ($past(pick_hi) ? hi_q : lo_q));

  // R4
  signed_range_chk: assert property (@(posedge clk) disable iff (rst)
    done && $past(saturate) && !$past(is_unsigned) |->
      (lo_q[ACCW-1:OPW-1] == '0) || (&lo_q[ACCW-1:OPW-1]));

  // R4
  underflow_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && cpu_mode[1] && saturate && !is_unsigned && unf_ev |=> lo_q == SMIN_A);

  // R5
  carry_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && cpu_mode[1] && saturate && is_unsigned && ovf_ev |=> &lo_q);
endmodule

bind mac_sat64 mac_sat64_chk #(.OPW(OPW), .ACCW(ACCW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .is_unsigned (is_unsigned),
  .saturate    (saturate),
  .pick_hi     (pick_hi),
  .cpu_mode    (cpu_mode),
  .lo_q        (lo_q),
  .hi_q        (hi_q),
  .dst_q       (dst_q),
  .done        (done),
  .rsv_exc     (rsv_exc),
  .ovf_ev      (ovf_ev),
  .unf_ev      (unf_ev)
);

// File: tb/sim_mac_sat64.sv
module sim_mac_sat64;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic        is_unsigned, saturate, pick_hi;
  logic [1:0]  cpu_mode;
  logic [63:0] lo_q, hi_q, dst_q;
  logic        done, rsv_exc;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_sat64 u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .is_unsigned(is_unsigned), .saturate(saturate), .pick_hi(pick_hi),
    .cpu_mode(cpu_mode), .lo_q(lo_q), .hi_q(hi_q), .dst_q(dst_q),
    .done(done), .rsv_exc(rsv_exc)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Behavioural reference state
  logic [63:0] m_lo = '0, m_hi = '0, m_dst = '0;
  logic        m_done = 0, m_exc = 0;

  task automatic check(string tag);
    n_chk++;
    if (lo_q !== m_lo || hi_q !== m_hi || dst_q !== m_dst || done !== m_done || rsv_exc !== m_exc) begin
      n_bad++;
      $display("FAIL %s: lo=%h hi=%h dst=%h done=%b exc=%b expected lo=%h hi=%h dst=%h done=%b exc=%b",
               tag, lo_q, hi_q, dst_q, done, rsv_exc, m_lo, m_hi, m_dst, m_done, m_exc);
    end
  endtask

  task automatic model(bit v, logic [31:0] a, logic [31:0] b, bit us, bit sat, bit ph, logic [1:0] md);
    logic signed [127:0] s;
    logic [127:0] u;
    logic [63:0]  nl;
    m_done = 0;
    m_exc  = 0;
    if (!v) return;
    if (md < 2'd2) begin
      m_exc = 1;
      return;
    end
    if (us) begin
      u  = {64'd0, m_lo} + ({96'd0, a} * {96'd0, b});
      nl = (sat && u[127:64] != 0) ? 64'hFFFF_FFFF_FFFF_FFFF : u[63:0];
      m_hi = '0;
    end else begin
      s = $signed({{64{m_lo[63]}}, m_lo}) + ($signed({{96{a[31]}}, a}) * $signed({{96{b[31]}}, b}));
      if (sat && s > 128'sh7FFF_FFFF)       nl = 64'h0000_0000_7FFF_FFFF;
      else if (sat && s < -128'sh8000_0000) nl = 64'hFFFF_FFFF_8000_0000;
      else                                  nl = s[63:0];
      m_hi = {64{nl[63]}};
    end
    m_lo   = nl;
    m_dst  = ph ? m_hi : m_lo;
    m_done = 1;
  endtask

  task automatic op(string tag, bit v, logic [31:0] a, logic [31:0] b, bit us, bit sat, bit ph, logic [1:0] md);
    in_valid = v; op_a = a; op_b = b;
    is_unsigned = us; saturate = sat; pick_hi = ph; cpu_mode = md;
    @(posedge clk);
    model(v, a, b, us, sat, ph, md);
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset(string tag);
    rst = 1; in_valid = 0;
    @(posedge clk);
    @(posedge clk);
    m_lo = '0; m_hi = '0; m_dst = '0; m_done = 0; m_exc = 0;
    @(negedge clk);
    rst = 0;
    check(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  initial begin
    logic [31:0] ext [5];
    ext[0] = 32'h0000_0000; ext[1] = 32'h0000_0001; ext[2] = 32'h7FFF_FFFF;
    ext[3] = 32'h8000_0000; ext[4] = 32'hFFFF_FFFF;
    rst = 1; in_valid = 0; op_a = 0; op_b = 0;
    is_unsigned = 0; saturate = 0; pick_hi = 0; cpu_mode = 2'd3;
    @(negedge clk);
    do_reset("R10 reset state");

    op("R2 signed 5 times -3",        1, 32'd5,        32'hFFFF_FFFD, 0, 0, 0, 2'd3);
    op("R7 destination returns HI",   1, 32'hFFFF_FFFF, 32'd7,        0, 0, 1, 2'd3);
    op("R2 most negative squared",    1, 32'h8000_0000, 32'h8000_0000, 0, 0, 1, 2'd3);
    op("R2 kernel mode min times max",1, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 0, 2'd2);
    op("R3 unsigned max square",      1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0, 2'd3);
    op("R3 unsigned wraps",           1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 1, 2'd3);
    op("R3 unsigned wraps again",     1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0, 2'd3);

    do_reset("R10 reset before clamp tests");
    op("R4 signed overflow clamp",    1, 32'h7FFF_FFFF, 32'd2,        0, 1, 0, 2'd3);
    op("R4 in range under clamp",     1, 32'hFFFF_FFFF, 32'd1,        0, 1, 0, 2'd3);
    op("R4 signed underflow clamp",   1, 32'h8000_0000, 32'h7FFF_FFFF, 0, 1, 1, 2'd3);
    op("R4 exact minimum kept",       1, 32'd0,         32'd9,        0, 1, 0, 2'd3);
    op("R2 no clamp when sat off",    1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0, 2'd3);

    do_reset("R10 reset before unsigned clamp");
    op("R5 small unsigned no floor",  1, 32'd3,         32'd4,        1, 1, 0, 2'd3);
    op("R5 unsigned near top",        1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 0, 2'd3);
    op("R5 carry clamps to ones",     1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 1, 2'd3);
    op("R5 all ones plus zero",       1, 32'd0,         32'hFFFF_FFFF, 1, 1, 0, 2'd3);
    op("R6 signed view of ones",      1, 32'd0,         32'd0,        0, 0, 1, 2'd3);

    op("R8 user mode refused",        1, 32'd11,        32'd13,       0, 0, 0, 2'd0);
    op("R8 supervisor refused",       1, 32'd11,        32'd13,       1, 1, 1, 2'd1);
    op("R11 idle ignores inputs",     0, 32'hDEAD_BEEF, 32'h1234_5678, 1, 1, 1, 2'd3);
    op("R11 idle in refused mode",    0, 32'h1,         32'h1,        0, 0, 0, 2'd0);

    for (int i = 0; i < 8; i++)
      op("R9 back to back", 1, 32'(i * 1000 + 1), 32'(i * 77 + 5), i[0], i[1], i[2], 2'd3);

    for (int c = 0; c < 8; c++)
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          op("R1 sweep of modes and extremes", 1, ext[x], ext[y], c[0], c[1], c[2], 2'(2 + (x % 2)));

    in_valid = 0;
    do_reset("R10 reset after sweep");
    op("R11 idle after reset", 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, 1, 2'd3);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule